// File: doc/BRIEF.md
# Timer Capture Channel with Trigger Sources

This block is one channel of a general-purpose timer, used for measuring time. An up-counter advances by one on every system-clock cycle in which a counting enable is high. The enable is produced elsewhere from the chosen count clock. The counter restarts from zero when a trigger arrives. A trigger can come from a software strobe, a synchronisation strobe shared by all channels, a match against a programmable limit value, or an edge on one of two external inputs. Every trigger is held pending and only takes effect on the next counting cycle. The counter can therefore still show a non-zero value for a while after a trigger.

Two capture registers take a snapshot of the counter on selected edges of external input A. The first register is called the A-snapshot and the second the B-snapshot. They fill in strict turn: first the A-snapshot, then the B-snapshot. This order starts over at every trigger, so a pair of snapshots always belongs to one interval. Each snapshot keeps a pending-read mark. An overwrite of an unread snapshot raises a sticky overrun flag. A counter wrap raises a sticky overflow flag. A status read strobe clears both flags.

Both external inputs pass through a synchroniser followed by an edge detector. A pulse on either input must therefore stay high for more than one system-clock period to be seen.

Top module: `tmr_capture_chan`

## Requirements
- R1: On a cycle with `cnt_en` high and no trigger, the counter goes up by one and wraps from all-ones to zero. On a cycle with `cnt_en` low it holds its value.
- R2: A `sw_trig` strobe leaves the counter unchanged until the next cycle with `cnt_en` high, and that cycle loads zero. A strobe given in a cycle where `cnt_en` is high loads zero in that same cycle. One trigger resets the counter once only.
- R3: A `sync_trig` strobe has exactly the same effect as `sw_trig`.
- R4: With `cfg_cmp_trig` high, a counting cycle in which the counter equals the limit register loads zero, so the count runs from 0 up to the limit. With `cfg_cmp_trig` low the count runs past the limit.
- R5: `cfg_ext_sel` picks the external trigger input (0 = input A, 1 = input B). `cfg_ext_edge` picks the trigger edge: 0 = none (disabled), 1 = rising, 2 = falling, 3 = both. An input change made before clock edge k is acted on at edge k+2, and the trigger is then deferred as in R2. Edges on the input that is not selected have no effect.
- R6: `cfg_ra_edge` and `cfg_rb_edge` use the same edge codes as R5 and select which edges of input A load each snapshot. A load stores the counter value that is present at the loading clock edge.
- R7: The A-snapshot loads only if the B-snapshot has loaded since the last A load, or if no A load has happened since the last trigger. The B-snapshot loads only after an A load that has had no B load since. Any trigger, including a limit match, resets this order so that the A-snapshot is next. A single input edge loads at most one snapshot.
- R8: A load into a snapshot that has not been read since its last load sets `sts_ovr` and replaces the old value. A `ra_rd` or `rb_rd` strobe clears that snapshot's pending-read mark.
- R9: `sts_rd` clears `sts_ovr` and `sts_cov`, unless a new event sets the flag in the same cycle.
- R10: `sts_cov` is set when the counter wraps by counting up. A trigger that zeroes an all-ones counter does not set it.
- R11: A `rc_wr` strobe writes `rc_wdata` into the limit register shown on `rc_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counting enable, one cycle per count tick |
| sw_trig | input | 1 | Software trigger strobe |
| sync_trig | input | 1 | Shared synchronisation trigger strobe |
| tin_a | input | 1 | External input A (asynchronous) |
| tin_b | input | 1 | External input B (asynchronous) |
| cfg_cmp_trig | input | 1 | Enable restart on a limit match |
| cfg_ext_sel | input | 1 | External trigger input select: 0 = A, 1 = B |
| cfg_ext_edge | input | 2 | External trigger edge code |
| cfg_ra_edge | input | 2 | Input A edge code that loads the A-snapshot |
| cfg_rb_edge | input | 2 | Input A edge code that loads the B-snapshot |
| rc_wr | input | 1 | Limit register write strobe |
| rc_wdata | input | CNT_W | Limit register write data |
| ra_rd | input | 1 | A-snapshot read strobe |
| rb_rd | input | 1 | B-snapshot read strobe |
| sts_rd | input | 1 | Status read strobe, clears the flags |
| cnt_val | output | CNT_W | Counter value |
| rc_val | output | CNT_W | Limit register value |
| ra_val | output | CNT_W | A-snapshot value |
| rb_val | output | CNT_W | B-snapshot value |
| sts_ovr | output | 1 | Sticky snapshot overrun flag |
| sts_cov | output | 1 | Sticky counter overflow flag |

## Verification
The bench builds the channel with `CNT_W` set to 8 and the default two-stage synchroniser. An 8-bit counter wraps after 256 counting cycles. This puts the overflow flag, and the case of a trigger landing on an all-ones count, within a short directed run. The default synchroniser depth fixes the input-to-action delay at three clock edges. The bench uses this delay to time each snapshot and each external trigger check exactly.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    // Decide whether a detected edge matches the selected edge code.
    function automatic logic edge_match(input logic [1:0] sel,
                                        input logic       rise,
                                        input logic       fall);
        logic hit;
        case (edge_sel_e'(sel))
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_ANY:  hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/tcap_insync.sv
module tcap_insync #(
    parameter int N_IN   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] din,
    output logic [N_IN-1:0] rise,
    output logic [N_IN-1:0] fall
);

    localparam int LAST = STAGES - 1;

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        typedef struct packed {
            logic [STAGES-1:0] chain;
            logic              prev;
        } sync_st_t;

        sync_st_t st_d, st_q;

        always_comb begin
            st_d       = st_q;
            st_d.chain = {st_q.chain[STAGES-2:0], din[i]};
            st_d.prev  = st_q.chain[LAST];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign rise[i] = st_q.chain[LAST] & ~st_q.prev;
        assign fall[i] = ~st_q.chain[LAST] & st_q.prev;
    end

endmodule

// File: rtl/tcap_counter.sv
module tcap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             trig_now,
    input  logic             cmp_en,
    input  logic             rc_wr,
    input  logic [CNT_W-1:0] rc_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] rc,
    output logic             cmp_fire,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rc;
        logic             pend;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    restart_req;
    logic    match;

    always_comb begin
        st_d        = st_q;
        restart_req = st_q.pend | trig_now;
        match       = cmp_en && (st_q.cnt == st_q.rc);
        cmp_fire    = cnt_en & match;
        wrap        = 1'b0;

        if (cnt_en) begin
            st_d.pend = 1'b0;
            if (restart_req || match) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                wrap     = (st_q.cnt == ALL_ONES);
            end
        end else begin
            st_d.pend = restart_req;
        end

        if (rc_wr) begin
            st_d.rc = rc_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign rc  = st_q.rc;

endmodule

// File: rtl/tcap_capture.sv
module tcap_capture
    import tcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             a_rise,
    input  logic             a_fall,
    input  logic [1:0]       ra_sel,
    input  logic [1:0]       rb_sel,
    input  logic             restart,
    input  logic             ra_rd,
    input  logic             rb_rd,
    output logic [CNT_W-1:0] ra,
    output logic [CNT_W-1:0] rb,
    output logic             ra_ld,
    output logic             rb_ld,
    output logic             ovr_evt
);

    typedef struct packed {
        logic [CNT_W-1:0] ra;
        logic [CNT_W-1:0] rb;
        logic             want_b;
        logic             ra_pend;
        logic             rb_pend;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    want_b_eff;

    always_comb begin
        st_d       = st_q;
        want_b_eff = restart ? 1'b0 : st_q.want_b;
        ra_ld      = edge_match(ra_sel, a_rise, a_fall) & ~want_b_eff;
        rb_ld      = edge_match(rb_sel, a_rise, a_fall) & want_b_eff;
        ovr_evt    = (ra_ld & st_q.ra_pend & ~ra_rd) |
                     (rb_ld & st_q.rb_pend & ~rb_rd);

        if (ra_ld) begin
            st_d.want_b = 1'b1;
        end else if (rb_ld) begin
            st_d.want_b = 1'b0;
        end else begin
            st_d.want_b = want_b_eff;
        end

        if (ra_ld) begin
            st_d.ra      = cnt;
            st_d.ra_pend = 1'b1;
        end else if (ra_rd) begin
            st_d.ra_pend = 1'b0;
        end

        if (rb_ld) begin
            st_d.rb      = cnt;
            st_d.rb_pend = 1'b1;
        end else if (rb_rd) begin
            st_d.rb_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ra = st_q.ra;
    assign rb = st_q.rb;

endmodule

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan
    import tcap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             sw_trig,
    input  logic             sync_trig,
    input  logic             tin_a,
    input  logic             tin_b,
    input  logic             cfg_cmp_trig,
    input  logic             cfg_ext_sel,
    input  logic [1:0]       cfg_ext_edge,
    input  logic [1:0]       cfg_ra_edge,
    input  logic [1:0]       cfg_rb_edge,
    input  logic             rc_wr,
    input  logic [CNT_W-1:0] rc_wdata,
    input  logic             ra_rd,
    input  logic             rb_rd,
    input  logic             sts_rd,
    output logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] rc_val,
    output logic [CNT_W-1:0] ra_val,
    output logic [CNT_W-1:0] rb_val,
    output logic             sts_ovr,
    output logic             sts_cov
);

    localparam int N_IN  = 2;
    localparam int IDX_A = 0;
    localparam int IDX_B = 1;

    typedef struct packed {
        logic ovr;
        logic cov;
    } sts_st_t;

    logic [N_IN-1:0] in_rise;
    logic [N_IN-1:0] in_fall;
    logic            ext_hit;
    logic            trig_now;
    logic            cmp_fire;
    logic            wrap;
    logic            ra_ld;
    logic            rb_ld;
    logic            ovr_evt;
    sts_st_t         sts_d, sts_q;

    tcap_insync #(
        .N_IN   (N_IN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({tin_b, tin_a}),
        .rise  (in_rise),
        .fall  (in_fall)
    );

    always_comb begin
        if (cfg_ext_sel) begin
            ext_hit = edge_match(cfg_ext_edge, in_rise[IDX_B], in_fall[IDX_B]);
        end else begin
            ext_hit = edge_match(cfg_ext_edge, in_rise[IDX_A], in_fall[IDX_A]);
        end
        trig_now = sw_trig | sync_trig | ext_hit;
    end

    tcap_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .trig_now (trig_now),
        .cmp_en   (cfg_cmp_trig),
        .rc_wr    (rc_wr),
        .rc_wdata (rc_wdata),
        .cnt      (cnt_val),
        .rc       (rc_val),
        .cmp_fire (cmp_fire),
        .wrap     (wrap)
    );

    tcap_capture #(
        .CNT_W (CNT_W)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt_val),
        .a_rise  (in_rise[IDX_A]),
        .a_fall  (in_fall[IDX_A]),
        .ra_sel  (cfg_ra_edge),
        .rb_sel  (cfg_rb_edge),
        .restart (trig_now | cmp_fire),
        .ra_rd   (ra_rd),
        .rb_rd   (rb_rd),
        .ra      (ra_val),
        .rb      (rb_val),
        .ra_ld   (ra_ld),
        .rb_ld   (rb_ld),
        .ovr_evt (ovr_evt)
    );

    // Sticky flags: a set event in the read cycle wins over the clear.
    always_comb begin
        sts_d     = sts_q;
        sts_d.ovr = ovr_evt | (sts_q.ovr & ~sts_rd);
        sts_d.cov = wrap | (sts_q.cov & ~sts_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= sts_d;
        end
    end

    assign sts_ovr = sts_q.ovr;
    assign sts_cov = sts_q.cov;

endmodule

// File: rtl/tcap_chk.sv
module tcap_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             sw_trig,
    input logic             cfg_cmp_trig,
    input logic             sts_rd,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] rc_val,
    input logic             sts_ovr,
    input logic             sts_cov,
    input logic             ra_ld,
    input logic             rb_ld
);

    AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt_val)); // R1

    AST_SOFT_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && sw_trig) |=> (cnt_val == '0)); // R2

    AST_CMP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cfg_cmp_trig && (cnt_val == rc_val)) |=> (cnt_val == '0)); // R4

    AST_OVR_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && !ra_ld && !rb_ld) |=> !sts_ovr); // R9

    AST_COV_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_cov) |-> ($past(cnt_val) == {CNT_W{1'b1}})); // R10

endmodule

bind tmr_capture_chan tcap_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_en       (cnt_en),
    .sw_trig      (sw_trig),
    .cfg_cmp_trig (cfg_cmp_trig),
    .sts_rd       (sts_rd),
    .cnt_val      (cnt_val),
    .rc_val       (rc_val),
    .sts_ovr      (sts_ovr),
    .sts_cov      (sts_cov),
    .ra_ld        (ra_ld),
    .rb_ld        (rb_ld)
);

// File: tb/tmr_capture_chan_tb.sv
module tmr_capture_chan_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0, sw_trig = 1'b0, sync_trig = 1'b0;
    logic         tin_a = 1'b0, tin_b = 1'b0;
    logic         cfg_cmp_trig = 1'b0, cfg_ext_sel = 1'b0;
    logic [1:0]   cfg_ext_edge = 2'd0, cfg_ra_edge = 2'd0, cfg_rb_edge = 2'd0;
    logic         rc_wr = 1'b0;
    logic [W-1:0] rc_wdata = '0;
    logic         ra_rd = 1'b0, rb_rd = 1'b0, sts_rd = 1'b0;
    logic [W-1:0] cnt_val, rc_val, ra_val, rb_val;
    logic         sts_ovr, sts_cov;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tmr_capture_chan #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .sw_trig(sw_trig),
        .sync_trig(sync_trig), .tin_a(tin_a), .tin_b(tin_b),
        .cfg_cmp_trig(cfg_cmp_trig), .cfg_ext_sel(cfg_ext_sel),
        .cfg_ext_edge(cfg_ext_edge), .cfg_ra_edge(cfg_ra_edge),
        .cfg_rb_edge(cfg_rb_edge), .rc_wr(rc_wr), .rc_wdata(rc_wdata),
        .ra_rd(ra_rd), .rb_rd(rb_rd), .sts_rd(sts_rd),
        .cnt_val(cnt_val), .rc_val(rc_val), .ra_val(ra_val), .rb_val(rb_val),
        .sts_ovr(sts_ovr), .sts_cov(sts_cov)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic zero_cnt();
        sw_trig = 1'b1; cnt_en = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0; cnt_en = 1'b0;
    endtask

    task automatic pulse_sw();
        sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
    endtask

    task automatic set_a(input logic v);
        tin_a = v; idle(3);
    endtask

    task automatic set_b(input logic v);
        tin_b = v; idle(3);
    endtask

    task automatic rd_ra();
        ra_rd = 1'b1; @(negedge clk); ra_rd = 1'b0;
    endtask

    task automatic rd_rb();
        rb_rd = 1'b1; @(negedge clk); rb_rd = 1'b0;
    endtask

    task automatic rd_sts();
        sts_rd = 1'b1; @(negedge clk); sts_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset count", cnt_val, 0);
        chk("R6 reset ra", ra_val, 0);
        chk("R6 reset rb", rb_val, 0);
        chk("R8 reset ovr", sts_ovr, 0);
        chk("R10 reset cov", sts_cov, 0);
    endtask

    task automatic t_count();
        zero_cnt();
        tick(7);
        chk("R1 count up", cnt_val, 7);
        idle(5);
        chk("R1 hold without enable", cnt_val, 7);
    endtask

    task automatic t_soft_trig();
        pulse_sw();
        idle(3);
        chk("R2 trigger deferred", cnt_val, 7);
        tick(1);
        chk("R2 trigger at next tick", cnt_val, 0);
        tick(3);
        chk("R2 trigger applied once", cnt_val, 3);
        zero_cnt();
        chk("R2 trigger with tick", cnt_val, 0);
        tick(2);
        chk("R2 resume after same-cycle trigger", cnt_val, 2);
    endtask

    task automatic t_sync_trig();
        sync_trig = 1'b1; @(negedge clk); sync_trig = 1'b0;
        idle(2);
        chk("R3 sync deferred", cnt_val, 2);
        tick(1);
        chk("R3 sync restarts", cnt_val, 0);
    endtask

    task automatic t_compare();
        rc_wdata = 8'd5; rc_wr = 1'b1; @(negedge clk); rc_wr = 1'b0;
        chk("R11 limit write", rc_val, 5);
        cfg_cmp_trig = 1'b1;
        zero_cnt();
        tick(5);
        chk("R4 reach limit", cnt_val, 5);
        tick(1);
        chk("R4 restart at limit", cnt_val, 0);
        tick(7);
        chk("R4 periodic count", cnt_val, 1);
        cfg_cmp_trig = 1'b0;
        zero_cnt();
        tick(7);
        chk("R4 compare disabled", cnt_val, 7);
    endtask

    task automatic t_ext_trig();
        cfg_ext_sel = 1'b0; cfg_ext_edge = 2'd1;
        zero_cnt();
        tick(4);
        set_a(1'b1);
        chk("R5 ext rising deferred", cnt_val, 4);
        tick(1);
        chk("R5 ext rising on A", cnt_val, 0);
        set_a(1'b0);
        tick(2);
        chk("R5 falling ignored when rising chosen", cnt_val, 2);
        cfg_ext_sel = 1'b1; cfg_ext_edge = 2'd2;
        set_b(1'b1);
        tick(1);
        chk("R5 rising ignored when falling chosen", cnt_val, 3);
        set_b(1'b0);
        chk("R5 ext falling deferred", cnt_val, 3);
        tick(1);
        chk("R5 ext falling on B", cnt_val, 0);
        cfg_ext_edge = 2'd0;
        set_b(1'b1);
        set_b(1'b0);
        tick(1);
        chk("R5 edge code none disables", cnt_val, 1);
        cfg_ext_edge = 2'd3;
        set_a(1'b1);
        set_a(1'b0);
        tick(1);
        chk("R5 unselected input ignored", cnt_val, 2);
        cfg_ext_edge = 2'd0; cfg_ext_sel = 1'b0;
    endtask

    task automatic t_capture_seq();
        cfg_ra_edge = 2'd1; cfg_rb_edge = 2'd2;
        zero_cnt();
        tick(10);
        set_a(1'b1);
        chk("R6 A-snapshot on rising", ra_val, 10);
        rd_ra();
        tick(5);
        set_a(1'b0);
        chk("R7 B-snapshot after A", rb_val, 15);
        rd_rb();
        tick(1);
        set_a(1'b1);
        chk("R7 A-snapshot after B", ra_val, 16);
        rd_ra();
        pulse_sw();
        tick(2);
        chk("R2 pending trigger applied", cnt_val, 1);
        set_a(1'b0);
        chk("R7 B blocked after trigger", rb_val, 15);
        set_a(1'b1);
        chk("R7 A first after trigger", ra_val, 1);
        rd_ra();
        tick(3);
        cfg_rb_edge = 2'd1;
        set_a(1'b0);
        set_a(1'b1);
        chk("R7 same edge loads B", rb_val, 4);
        chk("R7 same edge leaves A", ra_val, 1);
        rd_rb();
        tick(1);
        set_a(1'b0);
        set_a(1'b1);
        chk("R7 next edge loads A", ra_val, 5);
        rd_ra();
        chk("R8 no overrun when read", sts_ovr, 0);
    endtask

    task automatic t_overrun();
        tick(2);
        set_a(1'b0);
        set_a(1'b1);
        chk("R7 B load", rb_val, 7);
        set_a(1'b0);
        set_a(1'b1);
        chk("R7 A load", ra_val, 7);
        chk("R8 read A leaves no overrun", sts_ovr, 0);
        tick(1);
        set_a(1'b0);
        set_a(1'b1);
        chk("R8 overrun on unread B", sts_ovr, 1);
        chk("R8 B overwritten", rb_val, 8);
        rd_sts();
        chk("R9 status read clears overrun", sts_ovr, 0);
        rd_ra();
        rd_rb();
        set_a(1'b0);
        set_a(1'b1);
        chk("R8 A reload after read", ra_val, 8);
        chk("R8 read clears pending", sts_ovr, 0);
        rd_ra();
        cfg_ra_edge = 2'd0; cfg_rb_edge = 2'd0;
    endtask

    task automatic t_wrap();
        zero_cnt();
        tick(255);
        chk("R1 all ones", cnt_val, 255);
        chk("R10 no overflow yet", sts_cov, 0);
        tick(1);
        chk("R1 wrap to zero", cnt_val, 0);
        chk("R10 overflow set", sts_cov, 1);
        rd_sts();
        chk("R9 status read clears overflow", sts_cov, 0);
        tick(255);
        zero_cnt();
        chk("R10 trigger at all ones", cnt_val, 0);
        chk("R10 trigger sets no overflow", sts_cov, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_count();
        t_soft_trig();
        t_sync_trig();
        t_compare();
        t_ext_trig();
        t_capture_seq();
        t_overrun();
        t_wrap();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule